// File: doc/BRIEF.md
# Store Queue with Read-Miss Forwarding

This block sits on the store path between a write-through data cache and main memory. Each store that the cache accepts (a word address, a data word and a byte-enable mask) is placed in a small queue. The queue then sends its entries to memory one at a time, oldest first, over a valid/ready write port. The processor does not wait for memory on a store. It waits only when the queue has no free slot, or while a flush is in progress.

When the cache misses on a read, it presents the missed word address for one cycle. One cycle later the block returns a response. The response gives a byte mask and a data word. For each byte, these come from the youngest queued store to that address that wrote that byte. The cache lays these bytes over the word it gets from memory, so it never reads stale data from memory while newer stores are still waiting. A flush input stops new stores from entering and reports done once every queued store has left.

The queue depth must be a power of two, and at least two.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset the queue is empty. `mw_valid`, `st_stall`, `fwd_valid`, `fwd_hit`, `fwd_be` and `fwd_data` are all low or zero while `flush_req` is low.
- R2: A store offered with `st_valid` high while `st_stall` is low is accepted at that clock edge. From the next cycle it becomes available on the memory write port with the same address, data and byte mask.
- R3: Accepted stores leave on `mw_addr`/`mw_data`/`mw_be` strictly in acceptance order. One store leaves per cycle in which `mw_valid` and `mw_ready` are both high. While `mw_ready` is low, the presented store stays unchanged.
- R4: `st_stall` is high whenever the queue holds DEPTH stores. A store offered while `st_stall` is high is not accepted and never appears on the memory port.
- R5: A lookup with `rd_valid` high in cycle t produces `fwd_valid` high in cycle t+1. The result covers exactly the stores held in the queue during cycle t.
- R6: When no held store has a matching address with any byte enabled, the response has `fwd_hit` low, `fwd_be` zero and `fwd_data` zero. When `fwd_valid` is low, all three are zero.
- R7: For each byte lane b (bits 8b+7..8b), `fwd_be[b]` is set if some held store to the address enabled lane b. That lane of `fwd_data` is then taken from the youngest such store. Lanes with no such store read zero. `fwd_hit` equals `fwd_be` being nonzero.
- R8: A store that leaves the queue in the same cycle as a lookup still contributes to that lookup's result.
- R9: While `flush_req` is high, `st_stall` is high and no store is accepted. `flush_done` is high exactly when `flush_req` is high and the queue is empty.
- R10: A store accepted in the same cycle as a lookup is not part of that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | AW | Missed word address |
| fwd_valid | output | 1 | Lookup response valid |
| fwd_hit | output | 1 | At least one byte forwarded |
| fwd_be | output | DW/8 | Forwarded byte lanes |
| fwd_data | output | DW | Forwarded bytes, zero in other lanes |
| mw_valid | output | 1 | Memory write pending |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |
| mw_be | output | DW/8 | Memory write byte enables |
| flush_req | input | 1 | Block stores and drain |
| flush_done | output | 1 | Flush requested and queue empty |

## Verification
The bench uses several directed patterns. The first queues overlapping stores to one address: a full word followed by a half word. A lookup on that address shows whether lanes are taken from the youngest store or from the oldest. The second fills the queue and then looks up the oldest address in the very cycle that store drains. This separates a design that searches the pre-drain contents from one that searches the post-drain contents. The third offers a store and a lookup to the same address in the same cycle, which shows that a store is not visible to a lookup until after it has been accepted. A long random phase then runs over only four addresses, with random byte masks, stalled memory and flush pulses. Under these conditions matches on several entries, full-queue stalls and wrap-around of the queue pointers occur often.

// File: rtl/store_fwd_queue.sv
module store_fwd_queue #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BW    = DW / 8,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic [BW-1:0] push_be,
  input  logic          pop,
  output logic [AW-1:0] slot_addr [DEPTH],
  output logic [DW-1:0] slot_data [DEPTH],
  output logic [BW-1:0] slot_be   [DEPTH],
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [PW-1:0] tail;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // slot storage carries no reset: contents matter only below count
  always_ff @(posedge clk) begin
    if (push) begin
      slot_addr[tail] <= push_addr;
      slot_data[tail] <= push_data;
      slot_be[tail]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/store_fwd_search.sv
module store_fwd_search #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BW    = DW / 8,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] slot_addr [DEPTH],
  input  logic [DW-1:0] slot_data [DEPTH],
  input  logic [BW-1:0] slot_be   [DEPTH],
  input  logic [PW-1:0] head,
  input  logic [CW-1:0] count,
  output logic          fwd_valid,
  output logic          fwd_hit,
  output logic [BW-1:0] fwd_be,
  output logic [DW-1:0] fwd_data
);
  logic [BW-1:0] acc_be;
  logic [DW-1:0] acc_data;
  logic [PW-1:0] idx;

  // walk oldest to youngest so later matches overwrite earlier lanes
  always_comb begin
    acc_be   = '0;
    acc_data = '0;
    idx      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PW'(i);
      if (CW'(i) < count && slot_addr[idx] == rd_addr) begin
        for (int b = 0; b < BW; b++) begin
          if (slot_be[idx][b]) begin
            acc_be[b]          = 1'b1;
            acc_data[8*b +: 8] = slot_data[idx][8*b +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_hit   <= 1'b0;
      fwd_be    <= '0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= rd_valid;
      fwd_hit   <= rd_valid && (acc_be != '0);
      fwd_be    <= rd_valid ? acc_be   : '0;
      fwd_data  <= rd_valid ? acc_data : '0;
    end
  end

  // R5
  resp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> fwd_valid);
  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !fwd_valid |-> (!fwd_hit && fwd_be == '0 && fwd_data == '0));
endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int BW   = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [BW-1:0] st_be,
  output logic          st_stall,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          fwd_valid,
  output logic          fwd_hit,
  output logic [BW-1:0] fwd_be,
  output logic [DW-1:0] fwd_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data,
  output logic [BW-1:0] mw_be,
  input  logic          flush_req,
  output logic          flush_done
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] s_addr [DEPTH];
  logic [DW-1:0] s_data [DEPTH];
  logic [BW-1:0] s_be   [DEPTH];
  logic [PW-1:0] q_head;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty, push, pop;

  assign st_stall   = q_full || flush_req;
  assign push       = st_valid && !st_stall;
  assign mw_valid   = !q_empty;
  assign pop        = mw_valid && mw_ready;
  assign mw_addr    = s_addr[q_head];
  assign mw_data    = s_data[q_head];
  assign mw_be      = s_be[q_head];
  assign flush_done = flush_req && q_empty;

  store_fwd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk(clk), .rst(rst), .push(push), .push_addr(st_addr),
    .push_data(st_data), .push_be(st_be), .pop(pop),
    .slot_addr(s_addr), .slot_data(s_data), .slot_be(s_be),
    .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  store_fwd_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_search (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .slot_addr(s_addr), .slot_data(s_data), .slot_be(s_be),
    .head(q_head), .count(q_count), .fwd_valid(fwd_valid),
    .fwd_hit(fwd_hit), .fwd_be(fwd_be), .fwd_data(fwd_data)
  );

  // R3
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr)
      && $stable(mw_data) && $stable(mw_be)));
  // R4
  stalled_store_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_stall && !pop) |=> $stable(q_count));
  // R9
  flush_done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> (!mw_valid && st_stall));
endmodule

// File: tb/tb_store_fwd_buffer.sv
module tb_store_fwd_buffer;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0, rst = 1'b1;
  logic st_valid = 0, rd_valid = 0, mw_ready = 0, flush_req = 0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic st_stall, fwd_valid, fwd_hit, mw_valid, flush_done;
  logic [BW-1:0] fwd_be, mw_be;
  logic [DW-1:0] fwd_data, mw_data;
  logic [AW-1:0] mw_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  store_fwd_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (.*);

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; logic [BW-1:0] be; } ent_t;
  ent_t mq[$];
  logic e_fv, e_hit;
  logic [BW-1:0] e_be;
  logic [DW-1:0] e_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: queue of stores, lookup before update
  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      e_fv = 0; e_hit = 0; e_be = '0; e_data = '0;
    end else begin
      e_fv = rd_valid; e_be = '0; e_data = '0;
      if (rd_valid)
        foreach (mq[i])
          if (mq[i].a == rd_addr)
            for (int b = 0; b < BW; b++)
              if (mq[i].be[b]) begin
                e_be[b] = 1'b1;
                e_data[8*b +: 8] = mq[i].d[8*b +: 8];
              end
      e_hit = (e_be != '0);
      if (mq.size() > 0 && mw_ready) void'(mq.pop_front());
      if (st_valid && !(mq.size() == DEPTH || flush_req))
        ; // decided below against pre-pop size
    end
  end

  // push decision uses the size before the pop at this edge
  int pre_size;
  always @(posedge clk) pre_size <= mq.size();

  // separate push model so the stall decision uses the pre-edge size
  always @(posedge clk) begin
    if (!rst) begin
      #0;
      if (st_valid && !((mq_size_pre == DEPTH) || flush_req)) begin
        ent_t e;
        e.a = st_addr; e.d = st_data; e.be = st_be;
        mq.push_back(e);
      end
    end
  end

  int mq_size_pre;
  always @(negedge clk) mq_size_pre = mq.size();

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(mw_valid == (mq.size() > 0), "R2", mw_valid, mq.size() > 0);
      if (mq.size() > 0) begin
        chk(mw_addr == mq[0].a && mw_data == mq[0].d && mw_be == mq[0].be, "R3",
            {mw_addr, mw_data, mw_be}, {mq[0].a, mq[0].d, mq[0].be});
      end
      chk(st_stall == ((mq.size() == DEPTH) || flush_req), "R4", st_stall,
          (mq.size() == DEPTH) || flush_req);
      chk(flush_done == (flush_req && mq.size() == 0), "R9", flush_done,
          flush_req && mq.size() == 0);
      chk(fwd_valid == e_fv, "R5", fwd_valid, e_fv);
      chk(fwd_hit == e_hit && fwd_be == e_be && fwd_data == e_data,
          e_hit ? "R7" : "R6", {fwd_hit, fwd_be, fwd_data}, {e_hit, e_be, e_data});
    end
  end

  task automatic drive(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic [BW-1:0] sb, input bit rv, input logic [AW-1:0] ra,
                       input bit rdy, input bit fl);
    @(posedge clk); #1;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    rd_valid = rv; rd_addr = ra; mw_ready = rdy; flush_req = fl;
  endtask

  task automatic idle(input bit rdy);
    drive(0, '0, '0, '0, 0, '0, rdy, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(!mw_valid && !st_stall && !fwd_valid && !flush_done && fwd_be == '0, "R1",
        {mw_valid, st_stall, fwd_valid, flush_done}, 4'b0000);

    // overlapping stores to one address, memory stalled
    drive(1, 8'd5, 32'h11223344, 4'hF, 0, '0, 0, 0);
    drive(1, 8'd5, 32'hAABBCCDD, 4'b0011, 0, '0, 0, 0);
    drive(1, 8'd9, 32'h55667788, 4'hF, 0, '0, 0, 0);
    drive(0, '0, '0, '0, 1, 8'd5, 0, 0);
    idle(0);
    @(negedge clk);
    chk(fwd_be == 4'hF && fwd_data == 32'h1122CCDD, "R7", {fwd_be, fwd_data}, {4'hF, 32'h1122CCDD});

    // fill, then a store against a full queue
    drive(1, 8'd2, 32'h0000BEEF, 4'hF, 0, '0, 0, 0);
    drive(1, 8'd3, 32'hCAFEF00D, 4'hF, 0, '0, 0, 0);
    @(negedge clk);
    chk(st_stall == 1'b1, "R4", st_stall, 1'b1);
    // drain the head while looking it up
    drive(1, 8'd3, 32'hCAFEF00D, 4'hF, 1, 8'd5, 1, 0);
    drive(0, '0, '0, '0, 0, '0, 0, 0);
    @(negedge clk);
    chk(fwd_be == 4'hF && fwd_data == 32'h1122CCDD, "R8", {fwd_be, fwd_data}, {4'hF, 32'h1122CCDD});
    repeat (8) idle(1);

    // same-cycle store and lookup
    drive(1, 8'd7, 32'h12345678, 4'hF, 1, 8'd7, 0, 0);
    idle(0);
    @(negedge clk);
    chk(fwd_valid && !fwd_hit, "R10", {fwd_valid, fwd_hit}, 2'b10);

    // flush
    drive(1, 8'd8, 32'h0BADF00D, 4'hF, 0, '0, 0, 1);
    @(negedge clk);
    chk(st_stall && !flush_done, "R9", {st_stall, flush_done}, 2'b10);
    drive(0, '0, '0, '0, 0, '0, 1, 1);
    repeat (3) drive(0, '0, '0, '0, 0, '0, 1, 1);
    @(negedge clk);
    chk(flush_done == 1'b1 && !mw_valid, "R9", {flush_done, mw_valid}, 2'b10);
    idle(1);

    // random traffic over a narrow address range
    for (int k = 0; k < 3000; k++) begin
      drive($urandom_range(0, 1) == 1, AW'($urandom_range(0, 3)), $urandom,
            BW'($urandom), $urandom_range(0, 1) == 1, AW'($urandom_range(0, 3)),
            $urandom_range(0, 2) == 0, $urandom_range(0, 40) == 0);
    end
    idle(1);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule